// File: doc/BRIEF.md
# Buffered 16-bit timer

This block is a sixteen-bit up-counter that generates periodic interrupts and measures delays. It counts one of three sources: an instruction-rate tick, every system clock, or rising edges of an external clock level. The external level is sampled in the system clock domain and either passes through a flop synchronizer or bypasses it. The selected events are divided by 1, 2, 4 or 8 before they advance the count. When the count wraps from all-ones to zero, a sticky overflow flag is set. An interrupt request is raised while the flag, the local enable and two enables from the wider system are all high. A pulse on the special-event input clears the count.

Software reaches the timer through an 8-bit register bus. A 16-bit value can be read and written through a high-byte holding buffer, so both bytes are taken or applied in the same cycle. A control bit selects this buffered mode or direct byte access.

An edge-detect state machine with two states, `EXT_LOW` and `EXT_HIGH`, follows the chosen external level. The transition `EXT_LOW -> EXT_HIGH` happens when the level is seen high, and it produces the one-cycle external count event. The transition `EXT_HIGH -> EXT_LOW` happens when the level is seen low. In every other case the state holds.

Top module: `buffered_timer16`

## Requirements
- R1: After reset the count is 0x0000, the control register reads 0x00 (the timer is stopped), the status register reads 0x00, and `irq` is 0.
- R2: Address 2 is control. Bits [7:6] select the source: 00 counts cycles with `instr_tick` high, 01 counts every clock, and 10 or 11 counts rising edges of `ext_clk`. Bit 3 always reads 0.
- R3: Control bits [5:4] hold a value n. The count advances once per 2^n selected source events.
- R4: With control bit 1 at 0, the external level passes a two-flop synchronizer, and the count changes two clock edges later than with bit 1 at 1 (bypass). A level that stays high counts only once.
- R5: Control bit 0 enables counting. While it is 0, the count does not change except through bus writes or a special event.
- R6: Address 3 is status: bit 0 is the overflow flag and bit 1 is the local interrupt enable. A wrap from 0xFFFF to 0x0000 sets the flag. The flag clears only when status is written with bit 0 equal to 0; writing 1 has no effect on it.
- R7: `irq` is 1 exactly when the overflow flag, the local enable, `glb_ie` and `periph_ie` are all 1.
- R8: A high `special_evt` clears the count at the next edge. A counter write in the same cycle wins over the clear.
- R9: With control bit 2 at 1, a write to address 1 only loads the high-byte buffer. A write to address 0 then loads the whole count with {buffer, data} in a single edge.
- R10: With control bit 2 at 1, reading address 0 returns the low byte and copies the current high byte into the buffer. Reading address 1 returns the buffer.
- R11: With control bit 2 at 0, addresses 0 and 1 read and write the low and high count bytes directly.
- R12: Any write to address 0 or 1 clears the prescaler. A counter write wins over an increment in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (side effect on address 0 in buffered mode) |
| bus_addr | input | 2 | Register address: 0 count low, 1 count high, 2 control, 3 status |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register (combinational) |
| instr_tick | input | 1 | Instruction-rate count enable |
| ext_clk | input | 1 | External clock level sampled by `clk` |
| special_evt | input | 1 | Count clear request from a capture/compare unit |
| glb_ie | input | 1 | Global interrupt enable |
| periph_ie | input | 1 | Peripheral interrupt enable |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the timer with the default two-stage synchronizer. This lets it predict the exact edge at which an external rising edge lands in the count, and compare that edge with the bypass path. The wrap to zero is reached by preloading 0xFFFE over the bus instead of counting through the whole range. The bench runs all four prescale ratios from the same twenty source events. It also checks the buffered read while a carry ripples into the high byte, so the buffered and the live high bytes differ.

// File: rtl/btmr_pkg.sv
package btmr_pkg;
    localparam int BUS_W = 8;
    localparam int CNT_W = 2 * BUS_W;
    localparam int PS_W  = 2;
    localparam int PRE_W = (1 << PS_W) - 1;

    typedef enum logic [1:0] {
        SRC_INSTR = 2'b00,
        SRC_SYS   = 2'b01,
        SRC_EXT   = 2'b10,
        SRC_EXT_B = 2'b11
    } src_t;

    typedef enum logic [1:0] {
        A_CNT_LO = 2'd0,
        A_CNT_HI = 2'd1,
        A_CTRL   = 2'd2,
        A_STAT   = 2'd3
    } addr_t;

    typedef enum logic {
        EXT_LOW  = 1'b0,
        EXT_HIGH = 1'b1
    } edge_st_t;

    typedef struct packed {
        src_t            clksel;
        logic [PS_W-1:0] ps;
        logic            mode16;
        logic            bypass;
        logic            run;
    } ctrl_t;
endpackage

// File: rtl/btmr_tick_gen.sv
module btmr_tick_gen
    import btmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  src_t            src,
    input  logic            sync_bypass,
    input  logic [PS_W-1:0] ps,
    input  logic            instr_tick,
    input  logic            ext_clk,
    input  logic            pre_clr,
    output logic            cnt_tick
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_lvl;
    edge_st_t               st_q, st_d;
    logic                   ext_rise;
    logic                   src_ev, ev;
    logic [PRE_W-1:0]       pre_q, mask;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_clk};
    end

    assign ext_lvl = sync_bypass ? ext_clk : sync_q[SYNC_STAGES-1];

    // edge-detect state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= EXT_LOW;
        else        st_q <= st_d;
    end

    // next state and output
    always_comb begin
        st_d     = st_q;
        ext_rise = 1'b0;
        unique case (st_q)
            EXT_LOW: begin
                if (ext_lvl) begin
                    st_d     = EXT_HIGH;
                    ext_rise = 1'b1;
                end
            end
            EXT_HIGH: begin
                if (!ext_lvl) st_d = EXT_LOW;
            end
        endcase
    end

    always_comb begin
        unique case (src)
            SRC_INSTR:         src_ev = instr_tick;
            SRC_SYS:           src_ev = 1'b1;
            SRC_EXT, SRC_EXT_B: src_ev = ext_rise;
        endcase
    end

    assign ev = run && src_ev;

    always_comb begin
        mask = '0;
        for (int i = 0; i < PRE_W; i++) mask[i] = (i < int'(ps));
    end

    assign cnt_tick = ev && ((pre_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        pre_q <= '0;
        else if (pre_clr)  pre_q <= '0;
        else if (cnt_tick) pre_q <= '0;
        else if (ev)       pre_q <= pre_q + PRE_W'(1);
    end

    // R3: with a division above one, two count ticks never come back to back
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_tick |=> (!cnt_tick || ps == '0 || $past(pre_clr)));
endmodule

// File: rtl/btmr_count_core.sv
module btmr_count_core
    import btmr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    input  logic             mode16,
    input  logic             wr_lo,
    input  logic             wr_hi,
    input  logic             rd_lo,
    input  logic [BUS_W-1:0] wdata,
    input  logic             flag_wr,
    input  logic             flag_wbit,
    output logic [CNT_W-1:0] count,
    output logic [BUS_W-1:0] hbuf,
    output logic             ovf
);
    logic cnt_wr;
    logic wrap;

    assign cnt_wr = wr_lo || (wr_hi && !mode16);
    assign wrap   = inc && !cnt_wr && !clr && (count == '1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count <= '0;
        end else if (wr_lo) begin
            count <= mode16 ? {hbuf, wdata} : {count[CNT_W-1:BUS_W], wdata};
        end else if (wr_hi && !mode16) begin
            count <= {wdata, count[BUS_W-1:0]};
        end else if (clr) begin
            count <= '0;
        end else if (inc) begin
            count <= count + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                hbuf <= '0;
        else if (mode16 && wr_hi)  hbuf <= wdata;
        else if (mode16 && rd_lo)  hbuf <= count[CNT_W-1:BUS_W];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       ovf <= 1'b0;
        else if (wrap)                    ovf <= 1'b1;
        else if (flag_wr && !flag_wbit)   ovf <= 1'b0;
    end

    // R6: the wrap from all-ones sets the flag
    a_r6_flag_on_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (inc && !cnt_wr && !clr && count == '1) |=> (ovf && count == '0));
    // R6: the flag holds unless software writes a zero to it
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf && !(flag_wr && !flag_wbit)) |=> ovf);
    // R8: the special event empties the count
    a_r8_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (clr && !cnt_wr) |=> (count == '0));
    // R9: the buffered write applies both bytes at once
    a_r9_atomic_write: assert property (@(posedge clk) disable iff (!rst_n)
        (mode16 && wr_lo) |=> (count == {$past(hbuf), $past(wdata)}));
endmodule

// File: rtl/buffered_timer16.sv
module buffered_timer16
    import btmr_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [BUS_W-1:0] bus_wdata,
    output logic [BUS_W-1:0] bus_rdata,
    input  logic             instr_tick,
    input  logic             ext_clk,
    input  logic             special_evt,
    input  logic             glb_ie,
    input  logic             periph_ie,
    output logic             irq
);
    ctrl_t            ctrl_q;
    logic             tie_q;
    addr_t            addr;
    logic             wr_lo, wr_hi, wr_ctrl, wr_stat, rd_lo;
    logic             cnt_tick;
    logic [CNT_W-1:0] count;
    logic [BUS_W-1:0] hbuf;
    logic             ovf;

    assign addr    = addr_t'(bus_addr);
    assign wr_lo   = bus_wr && addr == A_CNT_LO;
    assign wr_hi   = bus_wr && addr == A_CNT_HI;
    assign wr_ctrl = bus_wr && addr == A_CTRL;
    assign wr_stat = bus_wr && addr == A_STAT;
    assign rd_lo   = bus_rd && addr == A_CNT_LO;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (wr_ctrl) begin
            ctrl_q.clksel <= src_t'(bus_wdata[7:6]);
            ctrl_q.ps     <= bus_wdata[5:4];
            ctrl_q.mode16 <= bus_wdata[2];
            ctrl_q.bypass <= bus_wdata[1];
            ctrl_q.run    <= bus_wdata[0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       tie_q <= 1'b0;
        else if (wr_stat) tie_q <= bus_wdata[1];
    end

    btmr_tick_gen #(.SYNC_STAGES(SYNC_STAGES)) u_tick (
        .clk         (clk),
        .rst_n       (rst_n),
        .run         (ctrl_q.run),
        .src         (ctrl_q.clksel),
        .sync_bypass (ctrl_q.bypass),
        .ps          (ctrl_q.ps),
        .instr_tick  (instr_tick),
        .ext_clk     (ext_clk),
        .pre_clr     (wr_lo || wr_hi),
        .cnt_tick    (cnt_tick)
    );

    btmr_count_core u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .inc       (cnt_tick),
        .clr       (special_evt),
        .mode16    (ctrl_q.mode16),
        .wr_lo     (wr_lo),
        .wr_hi     (wr_hi),
        .rd_lo     (rd_lo),
        .wdata     (bus_wdata),
        .flag_wr   (wr_stat),
        .flag_wbit (bus_wdata[0]),
        .count     (count),
        .hbuf      (hbuf),
        .ovf       (ovf)
    );

    always_comb begin
        unique case (addr)
            A_CNT_LO: bus_rdata = count[BUS_W-1:0];
            A_CNT_HI: bus_rdata = ctrl_q.mode16 ? hbuf : count[CNT_W-1:BUS_W];
            A_CTRL:   bus_rdata = {ctrl_q.clksel, ctrl_q.ps, 1'b0,
                                   ctrl_q.mode16, ctrl_q.bypass, ctrl_q.run};
            A_STAT:   bus_rdata = {{(BUS_W-2){1'b0}}, tie_q, ovf};
        endcase
    end

    assign irq = ovf && tie_q && glb_ie && periph_ie;

    // R5: a stopped timer keeps its count
    a_r5_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_q.run && !wr_lo && !(wr_hi && !ctrl_q.mode16) && !special_evt)
        |=> $stable(count));
    // R7: a request needs a pending overflow and the outside enables
    a_r7_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ovf && glb_ie && periph_ie));
endmodule

// File: tb/tb_buffered_timer16.sv
module tb_buffered_timer16;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_s = 1'b0, rd_s = 1'b0;
    logic [1:0] addr_s = 2'd0;
    logic [7:0] wdata_s = 8'd0;
    logic [7:0] rdata_w;
    logic       instr_s = 1'b0, ext_s = 1'b0, evt_s = 1'b0;
    logic       gie_s = 1'b0, peie_s = 1'b0;
    logic       irq_w;
    int         n_chk = 0;
    int         n_fail = 0;
    logic [7:0] d;

    localparam logic [1:0] LO = 2'd0, HI = 2'd1, CT = 2'd2, ST = 2'd3;

    always #4ns clk = ~clk;

    buffered_timer16 #(.SYNC_STAGES(2)) dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(wr_s), .bus_rd(rd_s),
        .bus_addr(addr_s), .bus_wdata(wdata_s), .bus_rdata(rdata_w),
        .instr_tick(instr_s), .ext_clk(ext_s), .special_evt(evt_s),
        .glb_ie(gie_s), .periph_ie(peie_s), .irq(irq_w)
    );

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    // all tasks start and end just after a falling edge
    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_wr(input logic [1:0] a, input logic [7:0] v);
        wr_s = 1'b1; addr_s = a; wdata_s = v;
        @(negedge clk);
        wr_s = 1'b0;
    endtask

    task automatic do_rd(input logic [1:0] a, output logic [7:0] v);
        rd_s = 1'b1; addr_s = a;
        #1ns v = rdata_w;
        @(negedge clk);
        rd_s = 1'b0;
    endtask

    task automatic setup(input logic [7:0] hi, input logic [7:0] lo);
        do_wr(CT, 8'h00);
        do_wr(HI, hi);
        do_wr(LO, lo);
    endtask

    task automatic t_reset;
        do_rd(LO, d); chk("R1 count low", d, 8'h00);
        do_rd(HI, d); chk("R1 count high", d, 8'h00);
        do_rd(CT, d); chk("R1 control", d, 8'h00);
        do_rd(ST, d); chk("R1 status", d, 8'h00);
        chk("R1 irq", irq_w, 1'b0);
    endtask

    task automatic t_stopped;
        setup(8'h00, 8'h00);
        do_wr(CT, 8'h40);
        idle(8);
        do_rd(LO, d); chk("R5 no count while stopped", d, 8'h00);
    endtask

    task automatic t_sysclk;
        setup(8'h00, 8'h00);
        do_wr(CT, 8'h41);
        idle(9);
        do_wr(CT, 8'h40);
        do_rd(LO, d); chk("R2 system clock source", d, 8'd10);
        do_wr(CT, 8'hFF);
        do_rd(CT, d); chk("R2 control readback bit 3 zero", d, 8'hF7);
    endtask

    task automatic t_instr;
        setup(8'h00, 8'h00);
        do_wr(CT, 8'h01);
        for (int i = 0; i < 5; i++) begin
            instr_s = 1'b1; idle(1);
            instr_s = 1'b0; idle(1);
        end
        do_wr(CT, 8'h00);
        do_rd(LO, d); chk("R2 instruction tick source", d, 8'd5);
    endtask

    task automatic t_prescale;
        for (int p = 0; p < 4; p++) begin
            setup(8'h00, 8'h00);
            do_wr(CT, 8'h41 | 8'(p << 4));
            idle(19);
            do_wr(CT, 8'h40 | 8'(p << 4));
            do_rd(LO, d); chk($sformatf("R3 prescale %0d", p), d, 8'(20 >> p));
        end
    endtask

    task automatic t_ext;
        setup(8'h00, 8'h00);
        do_wr(CT, 8'h83);
        ext_s = 1'b1; idle(1);
        do_rd(LO, d); chk("R4 bypass counts on first edge", d, 8'd1);
        idle(3);
        do_rd(LO, d); chk("R4 held level counts once", d, 8'd1);
        ext_s = 1'b0; idle(3);
        setup(8'h00, 8'h00);
        do_wr(CT, 8'h81);
        ext_s = 1'b1; idle(2);
        do_rd(LO, d); chk("R4 synchronized not yet counted", d, 8'd0);
        do_rd(LO, d); chk("R4 synchronized count after delay", d, 8'd1);
        ext_s = 1'b0; idle(3);
        do_wr(CT, 8'h00);
    endtask

    task automatic t_overflow;
        do_wr(ST, 8'h02);
        gie_s = 1'b1; peie_s = 1'b1;
        setup(8'hFF, 8'hFE);
        do_rd(ST, d); chk("R6 flag clear before wrap", d, 8'h02);
        do_wr(CT, 8'h41);
        idle(3);
        do_wr(CT, 8'h40);
        do_rd(ST, d); chk("R6 flag set on wrap", d, 8'h03);
        do_rd(LO, d); chk("R6 count low after wrap", d, 8'h02);
        do_rd(HI, d); chk("R6 count high after wrap", d, 8'h00);
        chk("R7 irq all enabled", irq_w, 1'b1);
        gie_s = 1'b0; #1ns chk("R7 irq global off", irq_w, 1'b0);
        gie_s = 1'b1; peie_s = 1'b0; #1ns chk("R7 irq peripheral off", irq_w, 1'b0);
        peie_s = 1'b1; #1ns chk("R7 irq back on", irq_w, 1'b1);
        idle(1);
        do_wr(ST, 8'h01);
        chk("R7 irq local enable off", irq_w, 1'b0);
        do_wr(ST, 8'h03);
        do_rd(ST, d); chk("R6 writing one keeps flag", d, 8'h03);
        do_wr(ST, 8'h02);
        do_rd(ST, d); chk("R6 writing zero clears flag", d, 8'h02);
        chk("R7 irq after flag clear", irq_w, 1'b0);
    endtask

    task automatic t_special;
        setup(8'h12, 8'h34);
        evt_s = 1'b1; idle(1); evt_s = 1'b0;
        do_rd(LO, d); chk("R8 clear low", d, 8'h00);
        do_rd(HI, d); chk("R8 clear high", d, 8'h00);
        setup(8'h12, 8'h34);
        evt_s = 1'b1;
        do_wr(LO, 8'h55);
        evt_s = 1'b0;
        do_rd(LO, d); chk("R8 write beats clear low", d, 8'h55);
        do_rd(HI, d); chk("R8 write beats clear high", d, 8'h12);
    endtask

    task automatic t_byte_mode;
        setup(8'h00, 8'h00);
        do_wr(HI, 8'h3C);
        do_rd(HI, d); chk("R11 direct high write", d, 8'h3C);
        do_rd(LO, d); chk("R11 low untouched", d, 8'h00);
    endtask

    task automatic t_wr16;
        setup(8'h00, 8'h55);
        do_wr(CT, 8'h04);
        do_wr(HI, 8'hAB);
        do_wr(CT, 8'h00);
        do_rd(HI, d); chk("R9 high write only buffered", d, 8'h00);
        do_wr(CT, 8'h04);
        do_wr(LO, 8'hCD);
        do_wr(CT, 8'h00);
        do_rd(HI, d); chk("R9 high applied with low", d, 8'hAB);
        do_rd(LO, d); chk("R9 low applied", d, 8'hCD);
    endtask

    task automatic t_rd16;
        do_wr(CT, 8'h04);
        do_wr(HI, 8'h12);
        do_wr(LO, 8'hFD);
        do_wr(CT, 8'h45);
        do_rd(LO, d); chk("R10 low read", d, 8'hFD);
        idle(5);
        do_rd(HI, d); chk("R10 high from buffer", d, 8'h12);
        do_wr(CT, 8'h44);
        do_wr(CT, 8'h00);
        do_rd(HI, d); chk("R10 live high moved on", d, 8'h13);
        do_rd(LO, d); chk("R10 live low", d, 8'h05);
    endtask

    task automatic t_pre_clear;
        setup(8'h00, 8'h00);
        do_wr(CT, 8'h71);
        idle(5);
        do_wr(LO, 8'h00);
        idle(6);
        do_wr(CT, 8'h70);
        do_rd(LO, d); chk("R12 prescaler cleared by write", d, 8'h00);
        setup(8'h00, 8'h00);
        do_wr(CT, 8'h41);
        idle(3);
        do_wr(LO, 8'h80);
        do_wr(CT, 8'h40);
        do_rd(LO, d); chk("R12 write beats increment", d, 8'h81);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_stopped();
        t_sysclk();
        t_instr();
        t_prescale();
        t_ext();
        t_overflow();
        t_special();
        t_byte_mode();
        t_wr16();
        t_rd16();
        t_pre_clear();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule